// File: doc/BRIEF.md
# Floppy Controller Register Front End

This block is the host-facing register layer of a PC-style floppy disk controller. It owns the drive control register: a two-bit drive select, an active-low run bit, a DMA enable and four motor enables. Each motor enable drives a motor pin directly, whether or not a drive is fitted. The run bit is the controller's only reset state. While it is low, the tape, data-rate and data-port writes are blocked, but the drive control register still accepts writes.

Setting the run bit from 0 to 1 starts a controller reset. It raises the interrupt, sends a one-cycle clear to the command engine and leaves power-down. A software reset through the data-rate register does the same, then reloads the control register with its default value. Reading the main status register releases the controller from reset and from power-down without any interrupt. The interrupt stays high until the command path acknowledges it through a clear input. The command engine, seek logic and DMA transfers sit outside this block.

Register addresses (`bus_addr`): 0 status A (read), 2 drive control (read/write), 3 tape select (write), 4 main status (read) / data rate (write), 5 data port (write). Reads of any other address return 0.

Top module: `fdc_regfront`

## Requirements
- R1: After `rst_n` low, the drive control register reads `{4'b0000, dma_avail, 1'b1, 2'b00}`, all motor pins are 0, and `irq`, `cmd_clear` and `sleep` are 0.
- R2: A write to address 2 is always stored, even while the run bit (bit 2) is 0, and address 2 reads back the stored byte. Layout: bits 1:0 drive select, bit 2 run (active low reset), bit 3 DMA enable, bits 7:4 motor enables for drives 0 to 3.
- R3: `motor_en[i]` equals control register bit 4+i for every drive i, whatever `second_drive_present` is.
- R4: A write to address 2 that takes bit 2 from 0 to 1 stores the written byte. From the next edge `irq` is 1, `cmd_clear` is 1 for exactly one cycle and `sleep` is 0.
- R5: A write to address 2 that takes bit 2 from 1 to 0 enters reset without raising `irq` or pulsing `cmd_clear`.
- R6: While bit 2 is 0, writes to addresses 3, 4 and 5 are ignored: `tape_sel`, `rate_sel` and `sleep` do not change and `fifo_wr` stays 0.
- R7: A write to address 4 with bit 7 set, when the run bit is 1, reloads the control register with the R1 value (motors off, drive 0), raises `irq` and pulses `cmd_clear` for one cycle. The run bit stays 1 afterwards.
- R8: An accepted write to address 4 loads `rate_sel` from bits 1:0. Bit 6 set makes `sleep` 1; this takes priority over the clearing by a software reset in the same write.
- R9: A read of address 4 returns bit 7 = `!xfer_busy` and all other bits 0. From the next edge the run bit is 1 and `sleep` is 0. `irq` and `cmd_clear` are not affected.
- R10: Address 0 reads bit 7 = `irq`, bit 6 = `!second_drive_present`, other bits 0.
- R11: `irq` stays 1 until `irq_clr` is sampled high. If `irq_clr` and a reset event fall in the same cycle, `irq` stays 1.
- R12: An accepted write to address 5 gives `fifo_wr` = 1 for one cycle after the edge, with `fifo_wdata` holding the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| second_drive_present | input | 1 | Second drive attached |
| dma_avail | input | 1 | DMA channel configured strap |
| xfer_busy | input | 1 | Transfer in progress (from the command engine) |
| irq_clr | input | 1 | Interrupt acknowledge from the command path |
| irq | output | 1 | Interrupt request |
| cmd_clear | output | 1 | One-cycle clear pulse to the command engine |
| sleep | output | 1 | Power-down state |
| motor_en | output | 4 | Motor pins for drives 0 to 3 |
| tape_sel | output | 2 | Tape drive select |
| rate_sel | output | 2 | Data rate select |
| fifo_wr | output | 1 | Data port write pulse |
| fifo_wdata | output | 8 | Data port write byte |

## Verification
The interrupt set from a controller reset and the interrupt acknowledge can land in the same clock edge. The bench provokes this by holding `irq_clr` high in the very cycle of a write that raises the run bit. It judges the result by seeing `irq` still high afterwards and low only after a lone acknowledge. A second overlap is a software reset combined with power-down in one data-rate write. There the bench expects `sleep` set while the control register returns to its default value.

// File: rtl/fdc_regfront_pkg.sv
package fdc_regfront_pkg;
   localparam int ADDR_W = 3;
   localparam int BYTE_W = 8;

   localparam logic [ADDR_W-1:0] ADR_STAT_A = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_TAPE   = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_MSRATE = 3'd4;
   localparam logic [ADDR_W-1:0] ADR_DATA   = 3'd5;

   // drive control register field positions
   localparam int CTRL_RUN_BIT = 2;
   localparam int CTRL_DMA_BIT = 3;
   localparam int CTRL_MOT_LSB = 4;

   // data rate register bits
   localparam int RATE_SWRST_BIT = 7;
   localparam int RATE_PWRDN_BIT = 6;

   // status bit positions
   localparam int MSR_RQM_BIT   = 7;
   localparam int STA_IRQ_BIT   = 7;
   localparam int STA_NODRV_BIT = 6;

   typedef struct packed {
      logic ctrl_wr;
      logic tape_wr;
      logic rate_wr;
      logic data_wr;
      logic msr_rd;
   } bus_evt_t;
endpackage

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg
   import fdc_regfront_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_DRIVES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_avail,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              force_run,
   input  logic              load_default,
   output logic [DATA_W-1:0] ctrl_q
);
   localparam int SEL_W = $clog2(NUM_DRIVES);

   generate
      if (SEL_W + 2 + NUM_DRIVES != DATA_W) begin : g_bad_layout
         $error("control register layout does not fill DATA_W");
      end
      if (CTRL_MOT_LSB != SEL_W + 2) begin : g_bad_motor_lsb
         $error("motor field position disagrees with select width");
      end
   endgenerate

   logic [DATA_W-1:0] dflt;

   always_comb begin
      dflt = '0;
      dflt[CTRL_RUN_BIT] = 1'b1;
      dflt[CTRL_DMA_BIT] = dma_avail;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= dflt;
      end else if (load_default) begin
         ctrl_q <= dflt;
      end else if (wr_en) begin
         ctrl_q <= wdata;
      end else if (force_run) begin
         ctrl_q[CTRL_RUN_BIT] <= 1'b1;
      end
   end
endmodule

// File: rtl/fdc_reset_ctrl.sv
module fdc_reset_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic run_q,
   input  logic ctrl_wr,
   input  logic ctrl_run_wbit,
   input  logic rate_wr,
   input  logic swrst_wbit,
   input  logic pwrdn_wbit,
   input  logic msr_rd,
   input  logic irq_clr,
   output logic accept,
   output logic swrst_evt,
   output logic irq,
   output logic cmd_clear,
   output logic sleep
);
   logic run_rise;
   logic reset_evt;
   logic pwrdn_evt;

   always_comb begin
      accept    = run_q;
      run_rise  = ctrl_wr && !run_q && ctrl_run_wbit;
      swrst_evt = rate_wr && accept && swrst_wbit;
      pwrdn_evt = rate_wr && accept && pwrdn_wbit;
      reset_evt = run_rise || swrst_evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq       <= 1'b0;
         cmd_clear <= 1'b0;
         sleep     <= 1'b0;
      end else begin
         cmd_clear <= reset_evt;
         if (reset_evt)
            irq <= 1'b1;
         else if (irq_clr)
            irq <= 1'b0;
         if (pwrdn_evt)
            sleep <= 1'b1;
         else if (reset_evt || msr_rd)
            sleep <= 1'b0;
      end
   end
endmodule

// File: rtl/fdc_aux_regs.sv
module fdc_aux_regs #(
   parameter int DATA_W = 8,
   parameter int TAPE_W = 2,
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              tape_wr,
   input  logic              rate_wr,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [TAPE_W-1:0] tape_sel,
   output logic [RATE_W-1:0] rate_sel,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_wdata
);
   generate
      if (TAPE_W > DATA_W || RATE_W > DATA_W - 2) begin : g_bad_field
         $error("auxiliary field wider than the bus allows");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tape_sel   <= '0;
         rate_sel   <= '0;
         fifo_wr    <= 1'b0;
         fifo_wdata <= '0;
      end else begin
         fifo_wr <= data_wr && accept;
         if (data_wr && accept)
            fifo_wdata <= wdata;
         if (tape_wr && accept)
            tape_sel <= wdata[TAPE_W-1:0];
         if (rate_wr && accept)
            rate_sel <= wdata[RATE_W-1:0];
      end
   end
endmodule

// File: rtl/fdc_rd_mux.sv
module fdc_rd_mux
   import fdc_regfront_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ctrl_q,
   input  logic              irq,
   input  logic              second_drive_present,
   input  logic              xfer_busy,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      unique case (addr)
         ADR_STAT_A: begin
            rdata[STA_IRQ_BIT]   = irq;
            rdata[STA_NODRV_BIT] = !second_drive_present;
         end
         ADR_CTRL:   rdata = ctrl_q;
         ADR_MSRATE: rdata[MSR_RQM_BIT] = !xfer_busy;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/fdc_regfront.sv
module fdc_regfront
   import fdc_regfront_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int TAPE_W     = 2,
   parameter int RATE_W     = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [BYTE_W-1:0]     bus_wdata,
   output logic [BYTE_W-1:0]     bus_rdata,
   input  logic                  second_drive_present,
   input  logic                  dma_avail,
   input  logic                  xfer_busy,
   input  logic                  irq_clr,
   output logic                  irq,
   output logic                  cmd_clear,
   output logic                  sleep,
   output logic [NUM_DRIVES-1:0] motor_en,
   output logic [TAPE_W-1:0]     tape_sel,
   output logic [RATE_W-1:0]     rate_sel,
   output logic                  fifo_wr,
   output logic [BYTE_W-1:0]     fifo_wdata
);
   bus_evt_t          evt;
   logic [BYTE_W-1:0] ctrl_q;
   logic              accept;
   logic              swrst_evt;

   always_comb begin
      evt.ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
      evt.tape_wr = bus_wr && (bus_addr == ADR_TAPE);
      evt.rate_wr = bus_wr && (bus_addr == ADR_MSRATE);
      evt.data_wr = bus_wr && (bus_addr == ADR_DATA);
      evt.msr_rd  = bus_rd && (bus_addr == ADR_MSRATE);
   end

   fdc_ctrl_reg #(.DATA_W(BYTE_W), .NUM_DRIVES(NUM_DRIVES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .dma_avail    (dma_avail),
      .wr_en        (evt.ctrl_wr),
      .wdata        (bus_wdata),
      .force_run    (evt.msr_rd),
      .load_default (swrst_evt),
      .ctrl_q       (ctrl_q)
   );

   fdc_reset_ctrl u_rst (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_q         (ctrl_q[CTRL_RUN_BIT]),
      .ctrl_wr       (evt.ctrl_wr),
      .ctrl_run_wbit (bus_wdata[CTRL_RUN_BIT]),
      .rate_wr       (evt.rate_wr),
      .swrst_wbit    (bus_wdata[RATE_SWRST_BIT]),
      .pwrdn_wbit    (bus_wdata[RATE_PWRDN_BIT]),
      .msr_rd        (evt.msr_rd),
      .irq_clr       (irq_clr),
      .accept        (accept),
      .swrst_evt     (swrst_evt),
      .irq           (irq),
      .cmd_clear     (cmd_clear),
      .sleep         (sleep)
   );

   fdc_aux_regs #(.DATA_W(BYTE_W), .TAPE_W(TAPE_W), .RATE_W(RATE_W)) u_aux (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .tape_wr    (evt.tape_wr),
      .rate_wr    (evt.rate_wr),
      .data_wr    (evt.data_wr),
      .wdata      (bus_wdata),
      .tape_sel   (tape_sel),
      .rate_sel   (rate_sel),
      .fifo_wr    (fifo_wr),
      .fifo_wdata (fifo_wdata)
   );

   fdc_rd_mux #(.DATA_W(BYTE_W)) u_mux (
      .addr                 (bus_addr),
      .ctrl_q               (ctrl_q),
      .irq                  (irq),
      .second_drive_present (second_drive_present),
      .xfer_busy            (xfer_busy),
      .rdata                (bus_rdata)
   );

   // motor pins follow the register for every drive, fitted or not
   generate
      for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_motor
         assign motor_en[d] = ctrl_q[CTRL_MOT_LSB + d];
      end
   endgenerate
endmodule

// File: rtl/fdc_regfront_chk.sv
module fdc_regfront_chk
   import fdc_regfront_pkg::*;
#(
   parameter int RATE_W = 2,
   parameter int TAPE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic [BYTE_W-1:0] ctrl_q,
   input logic              irq,
   input logic              irq_clr,
   input logic              cmd_clear,
   input logic              sleep,
   input logic [RATE_W-1:0] rate_sel,
   input logic [TAPE_W-1:0] tape_sel,
   input logic              fifo_wr
);
   p_rise_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_CTRL && !ctrl_q[CTRL_RUN_BIT] && bus_wdata[CTRL_RUN_BIT])
      |=> (irq && cmd_clear && !sleep));

   p_fall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_CTRL && ctrl_q[CTRL_RUN_BIT] && !bus_wdata[CTRL_RUN_BIT])
      |=> !cmd_clear);

   p_rate_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_MSRATE && !ctrl_q[CTRL_RUN_BIT])
      |=> ($stable(rate_sel) && $stable(sleep)));

   p_tape_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_TAPE && !ctrl_q[CTRL_RUN_BIT]) |=> $stable(tape_sel));

   p_data_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_DATA && !ctrl_q[CTRL_RUN_BIT]) |=> !fifo_wr);

   p_msr_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADR_MSRATE) |=> (ctrl_q[CTRL_RUN_BIT] && !sleep));

   p_clear_implies_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clear |-> irq);

   p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
endmodule

bind fdc_regfront fdc_regfront_chk #(.RATE_W(RATE_W), .TAPE_W(TAPE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .ctrl_q    (ctrl_q),
   .irq       (irq),
   .irq_clr   (irq_clr),
   .cmd_clear (cmd_clear),
   .sleep     (sleep),
   .rate_sel  (rate_sel),
   .tape_sel  (tape_sel),
   .fifo_wr   (fifo_wr)
);

// File: tb/fdc_regfront_tb.sv
`timescale 1ns/1ps
module fdc_regfront_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       second_drive_present = 1'b0;
   logic       dma_avail = 1'b1;
   logic       xfer_busy = 1'b0;
   logic       irq_clr = 1'b0;
   logic       irq, cmd_clear, sleep, fifo_wr;
   logic [3:0] motor_en;
   logic [1:0] tape_sel, rate_sel;
   logic [7:0] fifo_wdata;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   fdc_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .second_drive_present(second_drive_present), .dma_avail(dma_avail),
      .xfer_busy(xfer_busy), .irq_clr(irq_clr), .irq(irq),
      .cmd_clear(cmd_clear), .sleep(sleep), .motor_en(motor_en),
      .tape_sel(tape_sel), .rate_sel(rate_sel), .fifo_wr(fifo_wr),
      .fifo_wdata(fifo_wdata)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      rd(3'd2, v);
      chk("R1 ctrl after reset", v, 8'h0C);
      chk("R1 motors/irq/clear/sleep", {motor_en, irq, cmd_clear, sleep, 1'b0}, 8'h00);
      rd(3'd0, v);
      chk("R10 status A no second drive", v, 8'h40);
   endtask

   task automatic t_enter_reset();
      logic [7:0] v;
      wr(3'd2, 8'hF9);
      chk("R5 no irq/clear on entering reset", {6'b0, irq, cmd_clear}, 8'h00);
      rd(3'd2, v);
      chk("R2 ctrl readback", v, 8'hF9);
      chk("R3 motor pins for absent drives", {4'b0, motor_en}, 8'h0F);
      wr(3'd2, 8'h31);
      rd(3'd2, v);
      chk("R2 write accepted in reset", v, 8'h31);
   endtask

   task automatic t_gated_writes();
      wr(3'd3, 8'h03);
      chk("R6 tape ignored in reset", {6'b0, tape_sel}, 8'h00);
      wr(3'd4, 8'h43);
      chk("R6 rate ignored in reset", {5'b0, sleep, rate_sel}, 8'h00);
      wr(3'd5, 8'hAA);
      chk("R6 data write ignored in reset", {7'b0, fifo_wr}, 8'h00);
   endtask

   task automatic t_leave_reset();
      logic [7:0] v;
      wr(3'd2, 8'h25);
      chk("R4 irq and clear pulse", {6'b0, irq, cmd_clear}, 8'h03);
      @(negedge clk);
      chk("R4 clear is one cycle", {7'b0, cmd_clear}, 8'h00);
      rd(3'd2, v);
      chk("R4 written byte kept", v, 8'h25);
      rd(3'd0, v);
      chk("R10 status A irq pending", v, 8'hC0);
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk("R11 irq cleared by ack", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_rate_and_status();
      logic [7:0] v;
      wr(3'd4, 8'h02);
      chk("R8 rate field", {5'b0, sleep, rate_sel}, 8'h02);
      wr(3'd4, 8'h41);
      chk("R8 power-down", {5'b0, sleep, rate_sel}, 8'h05);
      rd(3'd4, v);
      chk("R9 status RQM idle", v, 8'h80);
      chk("R9 sleep cleared", {7'b0, sleep}, 8'h00);
      xfer_busy = 1'b1;
      rd(3'd4, v);
      chk("R9 status busy", v, 8'h00);
      xfer_busy = 1'b0;
      wr(3'd2, 8'h10);
      rd(3'd4, v);
      rd(3'd2, v);
      chk("R9 status read releases reset", v, 8'h14);
      chk("R9 no irq/clear from status read", {6'b0, irq, cmd_clear}, 8'h00);
   endtask

   task automatic t_data_tape();
      wr(3'd5, 8'h5A);
      chk("R12 fifo write pulse", {7'b0, fifo_wr}, 8'h01);
      chk("R12 fifo data", fifo_wdata, 8'h5A);
      @(negedge clk);
      chk("R12 pulse one cycle", {7'b0, fifo_wr}, 8'h00);
      wr(3'd3, 8'h02);
      chk("R6 tape accepted out of reset", {6'b0, tape_sel}, 8'h02);
   endtask

   task automatic t_soft_reset();
      logic [7:0] v;
      wr(3'd2, 8'hF6);
      wr(3'd4, 8'h81);
      chk("R7 irq and clear", {6'b0, irq, cmd_clear}, 8'h03);
      rd(3'd2, v);
      chk("R7 ctrl back to default", v, 8'h0C);
      chk("R7 motors off, rate loaded", {motor_en, 2'b0, rate_sel}, 8'h01);
   endtask

   task automatic t_collision();
      wr(3'd2, 8'h00);
      @(negedge clk);
      bus_addr = 3'd2; bus_wdata = 8'h04; bus_wr = 1'b1; irq_clr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; irq_clr = 1'b0;
      chk("R11 set wins over ack", {7'b0, irq}, 8'h01);
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk("R11 lone ack clears", {7'b0, irq}, 8'h00);
      wr(3'd4, 8'hC0);
      chk("R8 power-down beats soft reset clear", {6'b0, sleep, irq}, 8'h03);
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_enter_reset();
      t_gated_writes();
      t_leave_reset();
      t_rate_and_status();
      t_data_tape();
      t_soft_reset();
      t_collision();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule